// File: doc/BRIEF.md
# Four-Stage Right-Shift Register with Parallel Load

This block is a small storage element of `WIDTH` bits (four by default) that, on each rising clock edge, either keeps its contents, captures a parallel word, or moves every bit one place toward the low end. During that move, a serial bit enters at the top. Two control inputs choose the action. A shift request always wins: the register shifts even when a load is also requested. A load happens only when the shift request is low.

The lowest stage drives a serial output. A common use is to capture a word in parallel and then present its bits one per clock, lowest bit first, over the following shift cycles. The register clears as soon as the active-low reset input goes low. Reset release is synchronized to the clock through a two-flop stage before it reaches the register.

Top module: `shreg_top`

## Requirements
- R1: While `rst_n` is low, `par_out` is 0000 and `ser_out` is 0, without waiting for a clock edge.
- R2: With `shift_en`=0 and `load_en`=0 at a rising edge, `par_out` keeps its value.
- R3: With `shift_en`=0 and `load_en`=1 at a rising edge, `par_out` takes `par_in`, bit for bit.
- R4: With `shift_en`=1 at a rising edge, whatever `load_en` is, the new `par_out` is {`ser_in`, old `par_out[3:1]`}: bit 3 takes `ser_in` and bit i takes old bit i+1.
- R5: `ser_out` always equals `par_out[0]`.
- R6: Starting from 0101 and shifting with `ser_in` = 1, 1, 0, 1 gives the states 1010, 1101, 0110, 1011 in turn.
- R7: After 1011 is loaded, `ser_out` shows 1, and three shifts with `ser_in`=0 then show 1, 0, 1.
- R8: After `rst_n` rises, the first two rising edges still leave the register at 0000 whatever is requested; a load requested on the third edge takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchronizer |
| shift_en | input | 1 | Request a right shift; overrides `load_en` |
| load_en | input | 1 | Request a parallel load when `shift_en` is low |
| ser_in | input | 1 | Bit entering the top stage on a shift |
| par_in | input | WIDTH | Parallel word for a load |
| par_out | output | WIDTH | Register contents |
| ser_out | output | 1 | Lowest stage of the register |

## Verification
The clocked properties assume that the control and data inputs are settled at each rising edge. They also assume that checking begins only once the synchronized reset has been released, because updates before that point are suppressed on purpose. The bench changes every input on the falling clock edge, and its reset-release test waits until the synchronizer has passed the release before it checks any update. The sweep covers every stored word, every control pair, both serial bits and every parallel word. Each case is preceded by a load, so a known starting state is always present.

// File: rtl/shreg_pkg.sv
package shreg_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_LOAD  = 2'd1,
    OP_SHIFT = 2'd2
  } shreg_op_e;
endpackage

// File: rtl/shreg_rst_sync.sv
module shreg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/shreg_ctrl.sv
module shreg_ctrl
  import shreg_pkg::*;
(
  input  logic      shift_i,
  input  logic      load_i,
  output shreg_op_e op_o,
  output logic      upd_en_o
);
  always_comb begin
    if (shift_i) begin
      op_o = OP_SHIFT;
    end else if (load_i) begin
      op_o = OP_LOAD;
    end else begin
      op_o = OP_HOLD;
    end
  end

  assign upd_en_o = shift_i | load_i;
endmodule

// File: rtl/shreg_bit_mux.sv
module shreg_bit_mux
  import shreg_pkg::*;
(
  input  shreg_op_e op_i,
  input  logic      own_i,
  input  logic      par_i,
  input  logic      up_i,
  output logic      nxt_o
);
  always_comb begin
    unique case (op_i)
      OP_LOAD:  nxt_o = par_i;
      OP_SHIFT: nxt_o = up_i;
      default:  nxt_o = own_i;
    endcase
  end
endmodule

// File: rtl/shreg_top.sv
module shreg_top
  import shreg_pkg::*;
#(
  parameter int WIDTH      = 4,
  parameter int SYNC_DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             load_en,
  input  logic             ser_in,
  input  logic [WIDTH-1:0] par_in,
  output logic [WIDTH-1:0] par_out,
  output logic             ser_out
);
  localparam int TOP = WIDTH - 1;

  logic             rst_sync_n;
  shreg_op_e        op;
  logic             upd_en;
  logic [WIDTH-1:0] stage_q;
  logic [WIDTH-1:0] stage_nxt;

  shreg_rst_sync #(.STAGES(SYNC_DEPTH)) rst_sync_i (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  shreg_ctrl ctrl_i (
    .shift_i  (shift_en),
    .load_i   (load_en),
    .op_o     (op),
    .upd_en_o (upd_en)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    logic up_bit;
    if (i == TOP) begin : g_head
      assign up_bit = ser_in;
    end else begin : g_body
      assign up_bit = stage_q[i+1];
    end
    shreg_bit_mux mux_i (
      .op_i  (op),
      .own_i (stage_q[i]),
      .par_i (par_in[i]),
      .up_i  (up_bit),
      .nxt_o (stage_nxt[i])
    );
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      stage_q <= '0;
    end else if (upd_en) begin
      stage_q <= stage_nxt;
    end
  end

  assign par_out = stage_q;
  assign ser_out = stage_q[0];
endmodule

module shreg_chk #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         rst_ok,
  input logic         shift_en,
  input logic         load_en,
  input logic         ser_in,
  input logic [W-1:0] par_in,
  input logic [W-1:0] par_out,
  input logic         ser_out
);
  p_reset_clear_r1: assert property (@(posedge clk) !rst_n |-> (par_out == '0));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_ok)
    (!shift_en && !load_en) |=> $stable(par_out));

  p_load_r3: assert property (@(posedge clk) disable iff (!rst_ok)
    (!shift_en && load_en) |=> (par_out == $past(par_in)));

  p_shift_r4: assert property (@(posedge clk) disable iff (!rst_ok)
    shift_en |=> (par_out == {$past(ser_in), $past(par_out[W-1:1])}));

  p_serial_tap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ser_out == par_out[0]);
endmodule

bind shreg_top shreg_chk #(.W(WIDTH)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .rst_ok   (rst_sync_n),
  .shift_en (shift_en),
  .load_en  (load_en),
  .ser_in   (ser_in),
  .par_in   (par_in),
  .par_out  (par_out),
  .ser_out  (ser_out)
);

// File: tb/shreg_top_tb.sv
`timescale 1ns/1ps
module shreg_top_tb_top;
  localparam int W = 4;

  logic         clk;
  logic         rst_n;
  logic         shift_en;
  logic         load_en;
  logic         ser_in;
  logic [W-1:0] par_in;
  logic [W-1:0] par_out;
  logic         ser_out;

  int total = 0;
  int bad   = 0;

  shreg_top #(.WIDTH(W)) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (shift_en),
    .load_en  (load_en),
    .ser_in   (ser_in),
    .par_in   (par_in),
    .par_out  (par_out),
    .ser_out  (ser_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input logic [W-1:0] exp_q);
    total++;
    if (par_out !== exp_q || ser_out !== exp_q[0]) begin
      bad++;
      $display("FAIL %s: par_out=%b ser_out=%b expected par_out=%b ser_out=%b",
               req, par_out, ser_out, exp_q, exp_q[0]);
    end
  endtask

  task automatic tick(input logic sh, input logic ld, input logic si,
                      input logic [W-1:0] d);
    @(negedge clk);
    shift_en = sh; load_en = ld; ser_in = si; par_in = d;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [W-1:0] model(input logic [W-1:0] q, input logic sh,
                                         input logic ld, input logic si,
                                         input logic [W-1:0] d);
    if (sh) return (W'(si) << (W-1)) | (q >> 1);
    if (ld) return d;
    return q;
  endfunction

  initial begin
    #(20 * 150000);
    total++; bad++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [W-1:0] e;
    rst_n = 1'b0; shift_en = 0; load_en = 0; ser_in = 0; par_in = '0;
    #5;
    check("R1 reset at start", 4'b0000);
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset held", 4'b0000);

    // R8: loads on the first two edges after release are ignored
    @(negedge clk);
    rst_n = 1'b1; load_en = 1'b1; par_in = 4'b1111;
    @(posedge clk); #1;
    check("R8 edge 1 ignored", 4'b0000);
    @(posedge clk); #1;
    check("R8 edge 2 ignored", 4'b0000);
    @(posedge clk); #1;
    check("R8 edge 3 loads", 4'b1111);

    // R6: shift sequence from 0101
    tick(0, 1, 0, 4'b0101);
    check("R3 load 0101", 4'b0101);
    tick(1, 0, 1, 4'b0000); check("R6 step 1", 4'b1010);
    tick(1, 0, 1, 4'b0000); check("R6 step 2", 4'b1101);
    tick(1, 1, 0, 4'b1111); check("R6 step 3 shift over load R4", 4'b0110);
    tick(1, 0, 1, 4'b0000); check("R6 step 4", 4'b1011);

    // R7: load then serial read-out
    tick(0, 1, 0, 4'b1011); check("R7 loaded, ser_out=1", 4'b1011);
    tick(1, 0, 0, 4'b0000); check("R7 shift 1 ser_out=1", 4'b0101);
    tick(1, 0, 0, 4'b0000); check("R7 shift 2 ser_out=0", 4'b0010);
    tick(1, 0, 0, 4'b0000); check("R7 shift 3 ser_out=1", 4'b0001);
    tick(0, 0, 1, 4'b1111); check("R2 hold after read-out", 4'b0001);

    // Exhaustive sweep: start word x control pair x serial bit x data word
    for (int s = 0; s < 16; s++) begin
      for (int c = 0; c < 4; c++) begin
        for (int b = 0; b < 2; b++) begin
          for (int d = 0; d < 16; d++) begin
            logic sh, ld;
            sh = c[1]; ld = c[0];
            tick(0, 1, 0, W'(s));
            tick(sh, ld, b[0], W'(d));
            e = model(W'(s), sh, ld, b[0], W'(d));
            if (sh)      check("R4 sweep shift", e);
            else if (ld) check("R3 sweep load", e);
            else         check("R2 sweep hold", e);
          end
        end
      end
    end
    check("R5 serial tap after sweep", e);

    // R1: asynchronous clear mid-run
    tick(0, 1, 0, 4'b1010);
    check("R3 load before reset", 4'b1010);
    @(negedge clk);
    shift_en = 0; load_en = 0;
    #3 rst_n = 1'b0;
    #1 check("R1 async clear", 4'b0000);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1 check("R1 cleared after release", 4'b0000);
    tick(0, 1, 0, 4'b0110); check("R3 load after reset", 4'b0110);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule